// File: doc/BRIEF.md
# Reorder Buffer with Register Rename Table

This block tracks in-flight ALU instructions of a small out-of-order core. Each decoded instruction is allocated an entry at the tail of a circular buffer, and its tag is that entry's index. The instruction's source registers are resolved through a rename table. A source takes the committed register value, or the value of a finished producer, or it keeps the producer's tag and waits. The destination register is then mapped to the new entry. Completed results come back by tag. Each result is stored in its own entry and is also broadcast, so that every waiting source naming that tag captures the value.

Every cycle a picker hands the oldest entry whose operands are both present to an external ALU, through the execute port. The head entry retires once its result is present. Retirement writes the value into the committed register state held in the rename table and shows the value on the retire port. Retirement is strictly in program order. A flush, raised when the head instruction takes an exception, discards every entry and every mapping in one cycle. Committed values are kept. The buffer holds 8 entries and the core has 8 registers of 16 bits. Opcodes are 2 bits wide and are carried to the ALU without being interpreted.

Top module: `ooo_retire_buf`

## Requirements
- R1: After reset the block accepts dispatch (`disp_ready_o`=1), and both `exec_valid_o` and `ret_valid_o` are 0. Committed register i holds the value i, and no register is mapped.
- R2: In any cycle, at most one entry retires: the head entry, once its result is present. `ret_valid_o` is 1 in that cycle, with the destination on `ret_dst_o` and the value on `ret_val_o`. The retired values equal those of a sequential execution in dispatch order, even when results return out of order.
- R3: A dispatched source is resolved in this order. If the register is unmapped, the committed value is used. If it is mapped to an entry that holds its result, that entry's value is used. If the result for the mapped tag arrives in the same cycle, that value is used. Otherwise the source keeps the tag and waits.
- R4: Sources are resolved before the destination is remapped, so an instruction that reads and writes the same register sees the older value. After dispatch, the destination maps to the new entry.
- R5: On retirement, a register's mapping is cleared only when it still names the retiring entry. A younger writer of the same register keeps its mapping, so later readers wait for that younger writer.
- R6: An entry may issue when it is occupied, has no result yet, has not issued before, and both sources are valid. Of these entries, the one oldest counted from the head is presented on the execute port, with its tag, opcode and the two operand values. Each entry issues once.
- R7: A result carrying tag t marks entry t done and stores the value there. In the same cycle, every occupied entry whose waiting source names t captures the value.
- R8: The buffer holds 8 entries. `disp_ready_o` is 0 while all 8 are occupied, and a dispatch presented then is ignored.
- R9: `flush_i` discards all entries and clears all mappings, and the head, tail and count return to 0. Committed values are kept, and the next dispatch receives tag 0.
- R10: Tags are allocated in increasing order from the tail and wrap from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard all in-flight work |
| disp_valid_i | input | 1 | Dispatch request |
| disp_op_i | input | 2 | Opcode carried to the ALU |
| disp_dst_i | input | 3 | Destination register |
| disp_src1_i | input | 3 | First source register |
| disp_src2_i | input | 3 | Second source register |
| disp_ready_o | output | 1 | Buffer not full |
| exec_valid_o | output | 1 | An entry is issued this cycle |
| exec_tag_o | output | 3 | Tag of the issued entry |
| exec_op_o | output | 2 | Opcode of the issued entry |
| exec_opa_o | output | 16 | First operand |
| exec_opb_o | output | 16 | Second operand |
| res_valid_i | input | 1 | Result returned |
| res_tag_i | input | 3 | Tag of the result |
| res_val_i | input | 16 | Result value |
| ret_valid_o | output | 1 | Head retires this cycle |
| ret_dst_o | output | 3 | Retiring destination register |
| ret_val_o | output | 16 | Retiring value |

## Verification
Some properties are checked on every cycle. Every mapped register names an occupied entry whose destination is that register. Every occupied entry's destination is mapped to that entry or to a younger one. An issued entry always has both operands valid and no result yet. The count never exceeds the depth, the head advances by one on each retirement, and a flush leaves the buffer empty on the next cycle. Other behaviour is shown only by the bench's scenarios, which compare retired values against a sequential model of the program. These scenarios cover:
- the order in which sources are resolved;
- out-of-order completion;
- a retiring writer that must not unmap a younger writer;
- oldest-first selection when an older entry is still waiting;
- the stall when full, and the wrap of the tags;
- committed state that survives a flush.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_NREGS = 8;
  localparam int unsigned DEF_XLEN  = 16;
  localparam int unsigned DEF_OPW   = 2;

  typedef enum logic [1:0] {
    SRC_ARCH  = 2'd0,
    SRC_ENTRY = 2'd1,
    SRC_BUS   = 2'd2,
    SRC_WAIT  = 2'd3
  } src_kind_e;
endpackage

// File: rtl/rrb_rename.sv
module rrb_rename #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned XLEN  = 16,
  parameter int unsigned TW    = 3,
  localparam int unsigned RW   = $clog2(NREGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       alloc_i,
  input  logic [RW-1:0]              alloc_reg_i,
  input  logic [TW-1:0]              alloc_tag_i,
  input  logic                       commit_i,
  input  logic [RW-1:0]              commit_reg_i,
  input  logic [TW-1:0]              commit_tag_i,
  input  logic [XLEN-1:0]            commit_val_i,
  output logic [NREGS-1:0]           map_v_o,
  output logic [NREGS-1:0][TW-1:0]   map_tag_o,
  output logic [NREGS-1:0][XLEN-1:0] arch_val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREGS; r++) begin
        map_v_o[r]    <= 1'b0;
        map_tag_o[r]  <= '0;
        arch_val_o[r] <= XLEN'(r);
      end
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        if (commit_i && commit_reg_i == RW'(r)) arch_val_o[r] <= commit_val_i;
        if (flush_i) begin
          map_v_o[r] <= 1'b0;
        end else if (alloc_i && alloc_reg_i == RW'(r)) begin
          map_v_o[r]   <= 1'b1;
          map_tag_o[r] <= alloc_tag_i;
        end else if (commit_i && commit_reg_i == RW'(r) && map_tag_o[r] == commit_tag_i) begin
          map_v_o[r] <= 1'b0;  // only the youngest writer unmaps
        end
      end
    end
  end
endmodule

// File: rtl/rrb_pick.sv
module rrb_pick #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [TW-1:0]    head_i,
  output logic             valid_o,
  output logic [TW-1:0]    idx_o
);
  always_comb begin
    logic [TW-1:0] slot;
    valid_o = 1'b0;
    idx_o   = head_i;
    // walk youngest to oldest so the oldest request wins
    for (int k = DEPTH - 1; k >= 0; k--) begin
      slot = head_i + TW'(k);
      if (req_i[slot]) begin
        valid_o = 1'b1;
        idx_o   = slot;
      end
    end
  end
endmodule

// File: rtl/rrb_src.sv
module rrb_src import rrb_pkg::*; #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NREGS = 8,
  parameter int unsigned XLEN  = 16,
  localparam int unsigned TW   = $clog2(DEPTH),
  localparam int unsigned RW   = $clog2(NREGS)
) (
  input  logic [RW-1:0]              src_i,
  input  logic [NREGS-1:0]           map_v_i,
  input  logic [NREGS-1:0][TW-1:0]   map_tag_i,
  input  logic [NREGS-1:0][XLEN-1:0] arch_val_i,
  input  logic [DEPTH-1:0]           ent_done_i,
  input  logic [DEPTH-1:0][XLEN-1:0] ent_val_i,
  input  logic                       res_valid_i,
  input  logic [TW-1:0]              res_tag_i,
  input  logic [XLEN-1:0]            res_val_i,
  output logic                       rdy_o,
  output logic [XLEN-1:0]            val_o,
  output logic [TW-1:0]              tag_o
);
  src_kind_e kind;
  assign tag_o = map_tag_i[src_i];

  always_comb begin
    if (!map_v_i[src_i])                            kind = SRC_ARCH;
    else if (ent_done_i[tag_o])                     kind = SRC_ENTRY;
    else if (res_valid_i && res_tag_i == tag_o)     kind = SRC_BUS;
    else                                            kind = SRC_WAIT;
  end

  always_comb begin
    rdy_o = 1'b1;
    unique case (kind)
      SRC_ARCH:  val_o = arch_val_i[src_i];
      SRC_ENTRY: val_o = ent_val_i[tag_o];
      SRC_BUS:   val_o = res_val_i;
      default: begin
        rdy_o = 1'b0;
        val_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/ooo_retire_buf.sv
module ooo_retire_buf import rrb_pkg::*; #(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned NREGS = DEF_NREGS,
  parameter int unsigned XLEN  = DEF_XLEN,
  parameter int unsigned OPW   = DEF_OPW,
  localparam int unsigned TW   = $clog2(DEPTH),
  localparam int unsigned RW   = $clog2(NREGS),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            disp_valid_i,
  input  logic [OPW-1:0]  disp_op_i,
  input  logic [RW-1:0]   disp_dst_i,
  input  logic [RW-1:0]   disp_src1_i,
  input  logic [RW-1:0]   disp_src2_i,
  output logic            disp_ready_o,
  output logic            exec_valid_o,
  output logic [TW-1:0]   exec_tag_o,
  output logic [OPW-1:0]  exec_op_o,
  output logic [XLEN-1:0] exec_opa_o,
  output logic [XLEN-1:0] exec_opb_o,
  input  logic            res_valid_i,
  input  logic [TW-1:0]   res_tag_i,
  input  logic [XLEN-1:0] res_val_i,
  output logic            ret_valid_o,
  output logic [RW-1:0]   ret_dst_o,
  output logic [XLEN-1:0] ret_val_o
);
  logic [TW-1:0] head, tail;
  logic [CW-1:0] cnt;

  logic [DEPTH-1:0]           ent_vld, ent_done, ent_iss, s1_v, s2_v;
  logic [DEPTH-1:0][XLEN-1:0] ent_val, s1_val, s2_val;
  logic [DEPTH-1:0][TW-1:0]   s1_tag, s2_tag;
  logic [DEPTH-1:0][RW-1:0]   ent_dst;
  logic [DEPTH-1:0][OPW-1:0]  ent_op;

  logic [NREGS-1:0]           map_v;
  logic [NREGS-1:0][TW-1:0]   map_tag;
  logic [NREGS-1:0][XLEN-1:0] arch_val;

  logic disp_fire, ret_fire, iss_fire, pick_v;
  logic [TW-1:0] pick_idx;
  logic [DEPTH-1:0] elig;

  assign disp_ready_o = (cnt != CW'(DEPTH));
  assign disp_fire    = disp_valid_i && disp_ready_o && !flush_i;
  assign ret_fire     = ent_vld[head] && ent_done[head] && !flush_i;
  assign iss_fire     = pick_v && !flush_i;

  rrb_rename #(.NREGS(NREGS), .XLEN(XLEN), .TW(TW)) u_ren (
    .clk_i, .rst_ni, .flush_i,
    .alloc_i      (disp_fire),
    .alloc_reg_i  (disp_dst_i),
    .alloc_tag_i  (tail),
    .commit_i     (ret_fire),
    .commit_reg_i (ent_dst[head]),
    .commit_tag_i (head),
    .commit_val_i (ent_val[head]),
    .map_v_o      (map_v),
    .map_tag_o    (map_tag),
    .arch_val_o   (arch_val)
  );

  logic [1:0][RW-1:0]   src_reg;
  logic [1:0]           src_rdy;
  logic [1:0][XLEN-1:0] src_val;
  logic [1:0][TW-1:0]   src_tag;
  assign src_reg[0] = disp_src1_i;
  assign src_reg[1] = disp_src2_i;

  for (genvar g = 0; g < 2; g++) begin : g_src
    rrb_src #(.DEPTH(DEPTH), .NREGS(NREGS), .XLEN(XLEN)) u_src (
      .src_i       (src_reg[g]),
      .map_v_i     (map_v),
      .map_tag_i   (map_tag),
      .arch_val_i  (arch_val),
      .ent_done_i  (ent_done),
      .ent_val_i   (ent_val),
      .res_valid_i (res_valid_i),
      .res_tag_i   (res_tag_i),
      .res_val_i   (res_val_i),
      .rdy_o       (src_rdy[g]),
      .val_o       (src_val[g]),
      .tag_o       (src_tag[g])
    );
  end

  assign elig = ent_vld & ~ent_done & ~ent_iss & s1_v & s2_v;

  rrb_pick #(.DEPTH(DEPTH)) u_pick (
    .req_i   (elig),
    .head_i  (head),
    .valid_o (pick_v),
    .idx_o   (pick_idx)
  );

  assign exec_valid_o = iss_fire;
  assign exec_tag_o   = pick_idx;
  assign exec_op_o    = ent_op[pick_idx];
  assign exec_opa_o   = s1_val[pick_idx];
  assign exec_opb_o   = s2_val[pick_idx];

  assign ret_valid_o = ret_fire;
  assign ret_dst_o   = ent_dst[head];
  assign ret_val_o   = ent_val[head];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (flush_i) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (disp_fire) tail <= tail + 1'b1;
      if (ret_fire)  head <= head + 1'b1;
      cnt <= cnt + CW'(disp_fire) - CW'(ret_fire);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld <= '0; ent_done <= '0; ent_iss <= '0;
      s1_v <= '0; s2_v <= '0;
      ent_val <= '0; s1_val <= '0; s2_val <= '0;
      s1_tag <= '0; s2_tag <= '0; ent_dst <= '0; ent_op <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (flush_i) begin
          ent_vld[e] <= 1'b0;
        end else if (disp_fire && tail == TW'(e)) begin
          ent_vld[e]  <= 1'b1;
          ent_done[e] <= 1'b0;
          ent_iss[e]  <= 1'b0;
          ent_dst[e]  <= disp_dst_i;
          ent_op[e]   <= disp_op_i;
          s1_v[e]     <= src_rdy[0];
          s1_val[e]   <= src_val[0];
          s1_tag[e]   <= src_tag[0];
          s2_v[e]     <= src_rdy[1];
          s2_val[e]   <= src_val[1];
          s2_tag[e]   <= src_tag[1];
        end else begin
          if (ret_fire && head == TW'(e)) ent_vld[e] <= 1'b0;
          if (iss_fire && pick_idx == TW'(e)) ent_iss[e] <= 1'b1;
          if (res_valid_i && res_tag_i == TW'(e)) begin
            ent_done[e] <= 1'b1;
            ent_val[e]  <= res_val_i;
          end
          // result broadcast to waiting sources
          if (res_valid_i && ent_vld[e] && !s1_v[e] && s1_tag[e] == res_tag_i) begin
            s1_v[e]   <= 1'b1;
            s1_val[e] <= res_val_i;
          end
          if (res_valid_i && ent_vld[e] && !s2_v[e] && s2_tag[e] == res_tag_i) begin
            s2_v[e]   <= 1'b1;
            s2_val[e] <= res_val_i;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rrb_chk.sv
module rrb_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NREGS = 8,
  parameter int unsigned TW    = 3,
  parameter int unsigned RW    = 3,
  parameter int unsigned CW    = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     disp_ready_o,
  input logic                     exec_valid_o,
  input logic [TW-1:0]            exec_tag_o,
  input logic                     ret_valid_o,
  input logic [CW-1:0]            cnt_i,
  input logic [TW-1:0]            head_i,
  input logic [DEPTH-1:0]         ent_vld_i,
  input logic [DEPTH-1:0]         ent_done_i,
  input logic [DEPTH-1:0][RW-1:0] ent_dst_i,
  input logic [DEPTH-1:0]         s1_v_i,
  input logic [DEPTH-1:0]         s2_v_i,
  input logic [NREGS-1:0]         map_v_i,
  input logic [NREGS-1:0][TW-1:0] map_tag_i
);
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));

  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_i == '0 && !ret_valid_o && !exec_valid_o && disp_ready_o));

  p_head_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_o && !flush_i) |=> head_i == TW'($past(head_i) + 1'b1));

  p_issue_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> (ent_vld_i[exec_tag_o] && !ent_done_i[exec_tag_o]
                      && s1_v_i[exec_tag_o] && s2_v_i[exec_tag_o]));

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    p_map_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      map_v_i[r] |-> (ent_vld_i[map_tag_i[r]] && ent_dst_i[map_tag_i[r]] == RW'(r)));
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    p_dst_mapped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_vld_i[e] |-> (map_v_i[ent_dst_i[e]] &&
        TW'(map_tag_i[ent_dst_i[e]] - head_i) >= TW'(TW'(e) - head_i)));
  end
endmodule

bind ooo_retire_buf rrb_chk #(
  .DEPTH(DEPTH), .NREGS(NREGS), .TW(TW), .RW(RW), .CW(CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .disp_ready_o (disp_ready_o),
  .exec_valid_o (exec_valid_o),
  .exec_tag_o   (exec_tag_o),
  .ret_valid_o  (ret_valid_o),
  .cnt_i        (cnt),
  .head_i       (head),
  .ent_vld_i    (ent_vld),
  .ent_done_i   (ent_done),
  .ent_dst_i    (ent_dst),
  .s1_v_i       (s1_v),
  .s2_v_i       (s2_v),
  .map_v_i      (map_v),
  .map_tag_i    (map_tag)
);

// File: tb/sim_ooo_retire_buf.sv
module sim_ooo_retire_buf;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic disp_valid_i = 1'b0;
  logic [1:0] disp_op_i = '0;
  logic [2:0] disp_dst_i = '0, disp_src1_i = '0, disp_src2_i = '0;
  logic disp_ready_o, exec_valid_o, ret_valid_o;
  logic [2:0] exec_tag_o, ret_dst_o;
  logic [1:0] exec_op_o;
  logic [15:0] exec_opa_o, exec_opb_o, ret_val_o;
  logic res_valid_i = 1'b0;
  logic [2:0] res_tag_i = '0;
  logic [15:0] res_val_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ooo_retire_buf u0 (
    .clk_i(clk), .rst_ni, .flush_i,
    .disp_valid_i, .disp_op_i, .disp_dst_i, .disp_src1_i, .disp_src2_i, .disp_ready_o,
    .exec_valid_o, .exec_tag_o, .exec_op_o, .exec_opa_o, .exec_opb_o,
    .res_valid_i, .res_tag_i, .res_val_i,
    .ret_valid_o, .ret_dst_o, .ret_val_o
  );

  int checks = 0, fails = 0;

  // reference state
  logic [15:0] ref_rf [8];
  logic [2:0]  exp_dst [128];
  logic [15:0] exp_val [128];
  int exp_n = 0, cmp_n = 0;
  logic [2:0]  got_dst [128];
  logic [15:0] got_val [128];
  int ret_n = 0;
  int iss_log [128];
  int iss_n = 0;

  // ALU model
  bit alu_free = 1'b1, alu_lifo = 1'b0;
  int alu_credit = 0;
  logic [2:0]  pend_tag [32];
  logic [15:0] pend_val [32];
  int pend_n = 0;

  function automatic logic [15:0] alu_f(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a & b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (exec_valid_o) begin
        pend_tag[pend_n] = exec_tag_o;
        pend_val[pend_n] = alu_f(exec_op_o, exec_opa_o, exec_opb_o);
        pend_n++;
        iss_log[iss_n] = int'(exec_tag_o);
        iss_n++;
      end
      res_valid_i = 1'b0;
      if (pend_n > 0 && (alu_free || alu_credit > 0)) begin
        int k;
        k = alu_lifo ? pend_n - 1 : 0;
        res_valid_i = 1'b1;
        res_tag_i = pend_tag[k];
        res_val_i = pend_val[k];
        for (int j = k; j < pend_n - 1; j++) begin
          pend_tag[j] = pend_tag[j+1];
          pend_val[j] = pend_val[j+1];
        end
        pend_n--;
        if (!alu_free) alu_credit--;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk); #1;
      if (ret_valid_o) begin
        got_dst[ret_n] = ret_dst_o;
        got_val[ret_n] = ret_val_o;
        ret_n++;
      end
    end
  end

  task automatic disp(input logic [1:0] op, input int d, input int s1, input int s2);
    while (!disp_ready_o) @(negedge clk);
    disp_valid_i = 1'b1;
    disp_op_i = op;
    disp_dst_i = 3'(d);
    disp_src1_i = 3'(s1);
    disp_src2_i = 3'(s2);
    exp_val[exp_n] = alu_f(op, ref_rf[s1], ref_rf[s2]);
    exp_dst[exp_n] = 3'(d);
    ref_rf[d] = exp_val[exp_n];
    exp_n++;
    @(negedge clk);
    disp_valid_i = 1'b0;
  endtask

  task automatic drain(input string req);
    int w = 0;
    while (ret_n < exp_n && w < 400) begin
      @(negedge clk);
      w++;
    end
    repeat (6) @(negedge clk);
    chk(ret_n == exp_n, req, ret_n, exp_n);
    for (int i = cmp_n; i < exp_n && i < ret_n; i++) begin
      chk(got_dst[i] == exp_dst[i], req, int'(got_dst[i]), int'(exp_dst[i]));
      chk(got_val[i] == exp_val[i], req, int'(got_val[i]), int'(exp_val[i]));
    end
    cmp_n = exp_n;
  endtask

  task automatic do_flush();
    alu_free = 1'b0;
    alu_credit = 0;
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    pend_n = 0;
  endtask

  task automatic t_reset_state();
    chk(disp_ready_o == 1'b1, "R1 ready", int'(disp_ready_o), 1);
    chk(exec_valid_o == 1'b0, "R1 exec", int'(exec_valid_o), 0);
    chk(ret_valid_o == 1'b0, "R1 ret", int'(ret_valid_o), 0);
  endtask

  // R1 R3 R4: committed reads, same-register rename, dependent chains
  task automatic t_chain();
    alu_free = 1'b1; alu_lifo = 1'b0;
    disp(2'd0, 1, 2, 3);
    disp(2'd0, 3, 3, 3);
    disp(2'd1, 4, 1, 5);
    disp(2'd2, 1, 1, 4);
    disp(2'd0, 2, 1, 1);
    disp(2'd3, 6, 7, 2);
    disp(2'd0, 7, 0, 6);
    drain("R2 R3 R4 chain");
  endtask

  // R2 R7: results return youngest-first, retirement stays in order
  task automatic t_out_of_order();
    alu_free = 1'b0; alu_credit = 0; alu_lifo = 1'b1;
    disp(2'd0, 1, 1, 2);
    disp(2'd1, 2, 3, 4);
    disp(2'd2, 5, 5, 6);
    disp(2'd0, 6, 1, 2);
    disp(2'd0, 3, 7, 7);
    repeat (3) @(negedge clk);
    alu_free = 1'b1;
    drain("R2 R7 out-of-order completion");
    alu_lifo = 1'b0;
  endtask

  // R6 R10: oldest eligible first, waiting older entry skipped
  task automatic t_oldest();
    int base;
    do_flush();
    base = iss_n;
    disp(2'd0, 1, 2, 3);
    disp(2'd0, 4, 1, 2);
    disp(2'd2, 5, 2, 2);
    disp(2'd1, 6, 1, 3);
    repeat (3) @(negedge clk);
    chk(iss_n - base == 2, "R6 issues while held", iss_n - base, 2);
    chk(iss_log[base] == 0, "R6 R10 first issue", iss_log[base], 0);
    chk(iss_log[base+1] == 2, "R6 skip waiting entry", iss_log[base+1], 2);
    alu_credit = 1;
    repeat (5) @(negedge clk);
    chk(iss_n - base == 4, "R6 woken issues", iss_n - base, 4);
    chk(iss_log[base+2] == 1, "R6 oldest woken", iss_log[base+2], 1);
    chk(iss_log[base+3] == 3, "R6 next woken", iss_log[base+3], 3);
    alu_free = 1'b1;
    drain("R6 R7 oldest select");
  endtask

  // R5: a retiring older writer must not unmap a younger writer
  task automatic t_rename_keep();
    do_flush();
    disp(2'd0, 1, 2, 2);
    disp(2'd0, 1, 1, 3);
    repeat (2) @(negedge clk);
    alu_credit = 1;
    repeat (4) @(negedge clk);
    disp(2'd1, 4, 1, 0);
    repeat (2) @(negedge clk);
    alu_free = 1'b1;
    drain("R5 younger mapping kept");
  endtask

  // R8 R10: full stall, ignored dispatch, tag wrap
  task automatic t_full();
    do_flush();
    for (int i = 0; i < 8; i++) disp(2'd0, i, (i + 1) % 8, (i + 3) % 8);
    #1;
    chk(disp_ready_o == 1'b0, "R8 ready low when full", int'(disp_ready_o), 0);
    disp_valid_i = 1'b1; disp_op_i = 2'd0; disp_dst_i = 3'd2;
    disp_src1_i = 3'd5; disp_src2_i = 3'd6;
    repeat (2) @(negedge clk);
    disp_valid_i = 1'b0;
    alu_free = 1'b1;
    drain("R8 ignored dispatch while full");
    disp(2'd2, 3, 2, 4);
    drain("R10 after wrap");
    chk(iss_log[iss_n-1] == 0, "R10 tag wraps to 0", iss_log[iss_n-1], 0);
  endtask

  // R9: flush discards in-flight work, committed state survives
  task automatic t_flush();
    logic [15:0] snap [8];
    int snap_n, base_ret, base_iss;
    for (int i = 0; i < 8; i++) snap[i] = ref_rf[i];
    snap_n = exp_n;
    base_ret = ret_n;
    alu_free = 1'b0; alu_credit = 0;
    disp(2'd0, 1, 2, 3);
    disp(2'd1, 2, 1, 4);
    disp(2'd2, 5, 5, 5);
    repeat (2) @(negedge clk);
    do_flush();
    #1;
    chk(disp_ready_o == 1'b1, "R9 ready after flush", int'(disp_ready_o), 1);
    chk(exec_valid_o == 1'b0, "R9 no issue after flush", int'(exec_valid_o), 0);
    chk(ret_valid_o == 1'b0, "R9 no retire after flush", int'(ret_valid_o), 0);
    for (int i = 0; i < 8; i++) ref_rf[i] = snap[i];
    exp_n = snap_n;
    cmp_n = snap_n;
    alu_free = 1'b1;
    repeat (4) @(negedge clk);
    chk(ret_n == base_ret, "R9 flushed work never retires", ret_n, base_ret);
    base_iss = iss_n;
    disp(2'd0, 6, 1, 2);
    disp(2'd0, 7, 5, 6);
    drain("R9 committed state kept");
    chk(iss_log[base_iss] == 0, "R9 first tag after flush", iss_log[base_iss], 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ref_rf[i] = 16'(i);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    t_reset_state();
    t_chain();
    t_out_of_order();
    t_oldest();
    t_rename_keep();
    t_full();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", ret_n, exp_n);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule